// File: doc/BRIEF.md
# Vector Store Write Sequencer

This block turns one vector store command into an ordered series of register-file reads and line-aligned bus writes. A command names a source register (or a group of four consecutive registers), a scalar base address, a scalar data word, an element size and two mode bits. For each source register the block requests a read, captures the returned line and emits one write beat. A quarter store emits four beats per register instead. Each beat carries a byte strobe rotated to the address offset inside the line.

The block advances the running address either by a fixed line step or by a programmable stride. It limits the total bytes written to a budget computed from the element size and the scalar data word. It counts write responses that are still outstanding. It also exposes a bitmap of registers whose reads have not yet completed, plus a non-empty flag. Only one command is in flight at a time. Writes leave strictly in register order and then in quarter order.

Top module: `vsw_store_seq`

## Requirements
- R1: After reset `cmd_ready` is high, `rd_valid` and `wr_valid` are low, `busy_regs` is zero and `nempty` is low. A command is taken only in a cycle where `cmd_ready` is high, and `cmd_ready` stays low until the last write of that command has been issued.
- R2: The one-bit `rd_tag` equals bit (register address mod 4) of the 4-bit `cmd_tag`.
- R3: A read request stays up with a stable address while `rd_stall` is high or `rd_ready` is low. It completes only in a cycle with `rd_ready` high and `rd_stall` low. The next read starts only after all writes of the previous register are issued.
- R4: With `cmd_group` = 1 the command covers four registers, starting at `cmd_reg` and incrementing modulo 64, in ascending order.
- R5: `wr_addr` is the running address with bit 31 cleared and its low log2(line) bits cleared. `wr_id` equals the source register address.
- R6: With `cmd_func[1]` = 0 the running address advances after every beat by one line (16 bytes), or by a quarter line (4 bytes) for a quarter store.
- R7: With `cmd_func[1]` = 1 the running address advances after every beat by `cmd_data` × element size. `cmd_esize` is a byte count: 1, 2 or 4, and any other code acts as 1.
- R8: With `cmd_func[0]` = 1 the byte budget is esize × min(`cmd_data`, (line/esize) × m). Otherwise it is line × m. Here m is 4 for a group and 1 otherwise. Each beat writes min(budget left, beat capacity) bytes, and the budget falls by that amount but never below zero.
- R9: `wr_strb` sets bit (i + addr mod line) mod line for every i below the beat size, and no other bit.
- R10: A quarter store (`cmd_quarter` = 1) issues four beats per register with a capacity of line/4 bytes each. Beat k carries bytes 4k..4k+3 of the register replicated across the line.
- R11: `busy_regs` sets bit r for every register of a command at acceptance. Each bit clears when that register's read completes.
- R12: `nempty` is high while a write of an accepted command is not yet issued or an issued write has no response yet.
- R13: While MAX_OUT writes await a response, `wr_valid` is low. A response arriving in the same cycle frees its slot only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_quarter | input | 1 | 1 = quarter store, 0 = full store |
| cmd_group | input | 1 | 1 = four consecutive source registers |
| cmd_func | input | 3 | Bit 1 stride mode, bit 0 length-limited mode |
| cmd_esize | input | 3 | Element size in bytes (1, 2, 4) |
| cmd_reg | input | 6 | First source register |
| cmd_tag | input | 4 | Per-register read tag bits |
| cmd_addr | input | 32 | Scalar base address |
| cmd_data | input | 32 | Scalar data word (stride or element count) |
| rd_valid | output | 1 | Register read request |
| rd_ready | input | 1 | Register file ready |
| rd_stall | input | 1 | Hold the read this cycle |
| rd_addr | output | 6 | Register being read |
| rd_tag | output | 1 | Tag bit sent with the read |
| rd_data | input | 128 | Register line returned |
| wr_valid | output | 1 | Write address and data beat valid |
| wr_ready | input | 1 | Shared ready for address and data |
| wr_addr | output | 32 | Line-aligned write address |
| wr_id | output | 6 | Write ID (source register) |
| wr_data | output | 128 | Write data |
| wr_strb | output | 16 | Byte enables |
| resp_valid | input | 1 | Write response |
| resp_ready | output | 1 | Always ready for responses |
| busy_regs | output | 64 | Registers with a read still pending |
| nempty | output | 1 | Writes not yet issued or not yet answered |

## Verification
The bench builds the block with a 16-byte line and an outstanding-write limit of 3. A single held-back quarter-group command (sixteen beats) therefore runs into the limit, and the gating and release of `wr_valid` can be seen. The 16-byte line lets one command reach strobe wrap-around at every address offset. It also makes the line, quarter and 64-byte group budgets, and register-index wrap past 63, reachable in a few cycles. Read stalls and write back-pressure follow fixed cycle patterns, so every hold-and-complete combination shows up across the directed and random commands.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  localparam int FN_LEN_BIT    = 0;
  localparam int FN_STRIDE_BIT = 1;
  localparam int GROUP_REGS    = 4;
  localparam int QUARTER_BEATS = 4;
endpackage

// File: rtl/vsw_plan.sv
// Per-command byte budget and address step, evaluated at acceptance.
module vsw_plan #(
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int BUD_W      = 7
) (
  input  logic              quarter,
  input  logic              group,
  input  logic              len_mode,
  input  logic              stride_mode,
  input  logic [2:0]        esize,
  input  logic [ADDR_W-1:0] scalar,
  output logic [BUD_W-1:0]  budget,
  output logic [ADDR_W-1:0] step
);
  localparam int QTR = LINE_BYTES / 4;

  logic [1:0]       sz_lg;
  logic [1:0]       mult_lg;
  logic [BUD_W-1:0] elems;
  logic [BUD_W-1:0] cnt;

  always_comb begin
    case (esize)
      3'd2:    sz_lg = 2'd1;
      3'd4:    sz_lg = 2'd2;
      default: sz_lg = 2'd0;
    endcase
    mult_lg = group ? 2'd2 : 2'd0;
    elems   = (BUD_W'(LINE_BYTES) >> sz_lg) << mult_lg;
    cnt     = (scalar < ADDR_W'(elems)) ? scalar[BUD_W-1:0] : elems;
    budget  = len_mode ? (cnt << sz_lg) : (BUD_W'(LINE_BYTES) << mult_lg);
    if (stride_mode) step = scalar << sz_lg;
    else             step = quarter ? ADDR_W'(QTR) : ADDR_W'(LINE_BYTES);
  end
endmodule

// File: rtl/vsw_beat.sv
// Forms one write beat: aligned address, size, rotated strobe, data.
module vsw_beat #(
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int BUD_W      = 7
) (
  input  logic [ADDR_W-1:0]       run_addr,
  input  logic [BUD_W-1:0]        remain,
  input  logic                    quarter,
  input  logic [1:0]              beat_k,
  input  logic [LINE_BYTES*8-1:0] line,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [LINE_BYTES*8-1:0] wr_data,
  output logic [LINE_BYTES-1:0]   wr_strb,
  output logic [BUD_W-1:0]        size
);
  localparam int LSB_W = $clog2(LINE_BYTES);
  localparam int QTR   = LINE_BYTES / 4;
  localparam int QB    = QTR * 8;

  logic [BUD_W-1:0]        cap;
  logic [LINE_BYTES-1:0]   mask;
  logic [2*LINE_BYTES-1:0] wide;
  logic [QB-1:0]           chunk;
  logic [LINE_BYTES*8-1:0] repl;
  logic [LSB_W-1:0]        lsb;

  assign cap  = quarter ? BUD_W'(QTR) : BUD_W'(LINE_BYTES);
  assign size = (remain < cap) ? remain : cap;
  assign lsb  = run_addr[LSB_W-1:0];

  generate
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_mask
      assign mask[i] = BUD_W'(i) < size;
    end
    for (genvar g = 0; g < 4; g++) begin : g_repl
      assign repl[g*QB +: QB] = chunk;
    end
  endgenerate

  assign wide    = {{LINE_BYTES{1'b0}}, mask} << lsb;
  assign wr_strb = wide[LINE_BYTES-1:0] | wide[2*LINE_BYTES-1:LINE_BYTES];
  assign chunk   = line[beat_k*QB +: QB];
  assign wr_data = quarter ? repl : line;
  assign wr_addr = {1'b0, run_addr[ADDR_W-2:LSB_W], {LSB_W{1'b0}}};
endmodule

// File: rtl/vsw_track.sv
// Pending-read bitmap and outstanding-response counter.
module vsw_track #(
  parameter int REG_AW  = 6,
  parameter int MAX_OUT = 15,
  parameter int OUT_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_en,
  input  logic [REG_AW-1:0]      set_base,
  input  logic                   set_group,
  input  logic                   clr_en,
  input  logic [REG_AW-1:0]      clr_idx,
  input  logic                   issue,
  input  logic                   resp,
  output logic [(1<<REG_AW)-1:0] active,
  output logic [OUT_W-1:0]       out_cnt,
  output logic                   out_full
);
  localparam int NREGS = 1 << REG_AW;

  logic [NREGS-1:0] set_vec;
  logic [NREGS-1:0] clr_vec;
  logic             resp_ok;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (set_en) begin
      for (int g = 0; g < vsw_pkg::GROUP_REGS; g++) begin
        if (g == 0 || set_group) set_vec[set_base + REG_AW'(g)] = 1'b1;
      end
    end
    if (clr_en) clr_vec[clr_idx] = 1'b1;
  end

  assign resp_ok  = resp && (out_cnt != '0);
  assign out_full = out_cnt >= OUT_W'(MAX_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= '0;
      out_cnt <= '0;
    end else begin
      active <= (active & ~clr_vec) | set_vec;
      case ({issue, resp_ok})
        2'b10:   out_cnt <= out_cnt + 1'b1;
        2'b01:   out_cnt <= out_cnt - 1'b1;
        default: out_cnt <= out_cnt;
      endcase
    end
  end
endmodule

// File: rtl/vsw_store_seq.sv
module vsw_store_seq #(
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int REG_AW     = 6,
  parameter int TAG_W      = 4,
  parameter int MAX_OUT    = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_quarter,
  input  logic                    cmd_group,
  input  logic [2:0]              cmd_func,
  input  logic [2:0]              cmd_esize,
  input  logic [REG_AW-1:0]       cmd_reg,
  input  logic [TAG_W-1:0]        cmd_tag,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [ADDR_W-1:0]       cmd_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  input  logic                    rd_stall,
  output logic [REG_AW-1:0]       rd_addr,
  output logic                    rd_tag,
  input  logic [LINE_BYTES*8-1:0] rd_data,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [REG_AW-1:0]       wr_id,
  output logic [LINE_BYTES*8-1:0] wr_data,
  output logic [LINE_BYTES-1:0]   wr_strb,
  input  logic                    resp_valid,
  output logic                    resp_ready,
  output logic [(1<<REG_AW)-1:0]  busy_regs,
  output logic                    nempty
);
  import vsw_pkg::*;

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BUD_W  = $clog2(LINE_BYTES * 4 + 1);
  localparam int OUT_W  = $clog2(MAX_OUT + 1);

  seq_state_e        st;
  logic              cfg_quarter;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] step_q;
  logic [REG_AW-1:0] reg_q;
  logic [1:0]        left_q;
  logic [1:0]        beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUD_W-1:0]  remain_q;
  logic [LINE_W-1:0] line_q;

  logic [BUD_W-1:0]  plan_budget;
  logic [ADDR_W-1:0] plan_step;
  logic [BUD_W-1:0]  beat_size;
  logic [OUT_W-1:0]  out_cnt;
  logic              out_full;
  logic              accept;
  logic              rd_fire;
  logic              wr_fire;

  vsw_plan #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .BUD_W(BUD_W)) i_plan (
    .quarter     (cmd_quarter),
    .group       (cmd_group),
    .len_mode    (cmd_func[FN_LEN_BIT]),
    .stride_mode (cmd_func[FN_STRIDE_BIT]),
    .esize       (cmd_esize),
    .scalar      (cmd_data),
    .budget      (plan_budget),
    .step        (plan_step)
  );

  vsw_beat #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .BUD_W(BUD_W)) i_beat (
    .run_addr (addr_q),
    .remain   (remain_q),
    .quarter  (cfg_quarter),
    .beat_k   (beat_q),
    .line     (line_q),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_strb  (wr_strb),
    .size     (beat_size)
  );

  vsw_track #(.REG_AW(REG_AW), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)) i_track (
    .clk       (clk),
    .rst       (rst),
    .set_en    (accept),
    .set_base  (cmd_reg),
    .set_group (cmd_group),
    .clr_en    (rd_fire),
    .clr_idx   (reg_q),
    .issue     (wr_fire),
    .resp      (resp_valid),
    .active    (busy_regs),
    .out_cnt   (out_cnt),
    .out_full  (out_full)
  );

  assign cmd_ready  = (st == ST_IDLE);
  assign accept     = cmd_ready && cmd_valid;
  assign rd_valid   = (st == ST_READ);
  assign rd_fire    = rd_valid && rd_ready && !rd_stall;
  assign rd_addr    = reg_q;
  assign rd_tag     = tag_q[reg_q[1:0]];
  assign wr_valid   = (st == ST_WRITE) && !out_full;
  assign wr_fire    = wr_valid && wr_ready;
  assign wr_id      = reg_q;
  assign resp_ready = 1'b1;
  assign nempty     = (st != ST_IDLE) || (out_cnt != '0);

  always_ff @(posedge clk) begin
    if (rd_fire) line_q <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cfg_quarter <= 1'b0;
      tag_q       <= '0;
      step_q      <= '0;
      reg_q       <= '0;
      left_q      <= '0;
      beat_q      <= '0;
      addr_q      <= '0;
      remain_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            cfg_quarter <= cmd_quarter;
            tag_q       <= cmd_tag;
            step_q      <= plan_step;
            reg_q       <= cmd_reg;
            left_q      <= cmd_group ? 2'd3 : 2'd0;
            addr_q      <= cmd_addr;
            remain_q    <= plan_budget;
            st          <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ready && !rd_stall) begin
            beat_q <= '0;
            st     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_fire) begin
            addr_q   <= addr_q + step_q;
            remain_q <= remain_q - beat_size;
            if (cfg_quarter && beat_q != 2'(QUARTER_BEATS - 1)) begin
              beat_q <= beat_q + 1'b1;
            end else if (left_q != '0) begin
              reg_q  <= reg_q + 1'b1;
              left_q <= left_q - 1'b1;
              st     <= ST_READ;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsw_store_seq_chk.sv
module vsw_store_seq_chk #(
  parameter int LINE_BYTES = 16,
  parameter int REG_AW     = 6,
  parameter int MAX_OUT    = 15,
  parameter int OUT_W      = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic                   rd_stall,
  input logic [REG_AW-1:0]      rd_addr,
  input logic                   wr_valid,
  input logic [LINE_BYTES-1:0]  wr_strb,
  input logic                   quarter_q,
  input logic [OUT_W-1:0]       out_cnt,
  input logic [(1<<REG_AW)-1:0] busy_regs,
  input logic                   nempty
);
  // R1
  accept_starts_read_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> rd_valid && !cmd_ready);

  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && (rd_stall || !rd_ready) |=> rd_valid && $stable(rd_addr));

  // R3
  read_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !rd_valid);

  // R11
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_ready && !rd_stall |=> !busy_regs[$past(rd_addr)]);

  // R12
  idle_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !nempty |-> cmd_ready && (busy_regs == '0));

  // R13
  out_limit_chk: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= OUT_W'(MAX_OUT));

  // R10
  quarter_strb_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && quarter_q |-> $countones(wr_strb) <= LINE_BYTES / 4);
endmodule

bind vsw_store_seq vsw_store_seq_chk #(
  .LINE_BYTES (LINE_BYTES),
  .REG_AW     (REG_AW),
  .MAX_OUT    (MAX_OUT),
  .OUT_W      (OUT_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_stall  (rd_stall),
  .rd_addr   (rd_addr),
  .wr_valid  (wr_valid),
  .wr_strb   (wr_strb),
  .quarter_q (cfg_quarter),
  .out_cnt   (out_cnt),
  .busy_regs (busy_regs),
  .nempty    (nempty)
);

// File: tb/test_vsw_store_seq.sv
module test_vsw_store_seq;
  localparam int CLK_NS = 10;
  localparam int LB     = 16;
  localparam int MAXO   = 3;
  localparam int LIMIT  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic         cmd_valid = 0, cmd_ready, cmd_quarter = 0, cmd_group = 0;
  logic [2:0]   cmd_func = 0, cmd_esize = 1;
  logic [5:0]   cmd_reg = 0;
  logic [3:0]   cmd_tag = 0;
  logic [31:0]  cmd_addr = 0, cmd_data = 0;
  logic         rd_valid, rd_ready = 0, rd_stall = 0, rd_tag;
  logic [5:0]   rd_addr;
  logic [127:0] rd_data;
  logic         wr_valid, wr_ready = 0;
  logic [31:0]  wr_addr;
  logic [5:0]   wr_id;
  logic [127:0] wr_data;
  logic [15:0]  wr_strb;
  logic         resp_valid = 0, resp_ready, nempty;
  logic [63:0]  busy_regs;

  vsw_store_seq #(.LINE_BYTES(LB), .MAX_OUT(MAXO)) i_vsw_store_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_quarter(cmd_quarter), .cmd_group(cmd_group), .cmd_func(cmd_func),
    .cmd_esize(cmd_esize), .cmd_reg(cmd_reg), .cmd_tag(cmd_tag),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_stall(rd_stall), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_id(wr_id), .wr_data(wr_data), .wr_strb(wr_strb), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .busy_regs(busy_regs), .nempty(nempty)
  );

  function automatic logic [127:0] pat(input logic [5:0] r);
    logic [127:0] v;
    for (int j = 0; j < LB; j++) v[j*8 +: 8] = {r, 2'b00} ^ (8'(j) * 8'h11) ^ 8'h5A;
    return v;
  endfunction

  assign rd_data = pat(rd_addr);

  typedef struct {
    logic q; logic g; logic [2:0] fn; logic [2:0] es;
    logic [5:0] r; logic [3:0] t; logic [31:0] a; logic [31:0] d;
  } cmd_t;
  typedef struct { logic [5:0] a; logic t; int beats; } rd_t;
  typedef struct { logic [31:0] addr; logic [5:0] id; logic [127:0] data; logic [15:0] strb; } wr_t;

  cmd_t  cmdq[$];
  rd_t   rdq[$];
  wr_t   wq[$];
  int    ready_beats = 0;
  int    outst = 0;
  logic [63:0] act = '0;
  int    cyc = 0;
  bit    hold = 0;
  int    compared = 0, mismatched = 0;

  task automatic chk(input string req, input string what, input logic [127:0] actv, input logic [127:0] expv);
    compared++;
    if (actv !== expv) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, actv, expv);
    end
  endtask

  // Behavioural expansion of one command into expected reads and writes.
  task automatic expand(input cmd_t c);
    int sz, mult, beats, remain, step, cap, size, lsb, elems, cnt;
    logic [31:0] a;
    logic [5:0]  r;
    logic [127:0] src;
    wr_t w;
    sz    = (c.es == 3'd2) ? 2 : (c.es == 3'd4) ? 4 : 1;
    mult  = c.g ? 4 : 1;
    beats = c.q ? 4 : 1;
    elems = (LB / sz) * mult;
    cnt   = (c.d < 32'(elems)) ? int'(c.d) : elems;
    remain = c.fn[0] ? sz * cnt : LB * mult;
    step   = c.fn[1] ? int'(c.d) * sz : (c.q ? LB / 4 : LB);
    cap    = c.q ? LB / 4 : LB;
    a = c.a;
    r = c.r;
    for (int k = 0; k < mult; k++) begin
      rdq.push_back('{a: r, t: c.t[r[1:0]], beats: beats});
      act[r] = 1'b1;
      src = pat(r);
      for (int b = 0; b < beats; b++) begin
        size = (remain < cap) ? remain : cap;
        lsb  = int'(a[3:0]);
        w.addr = a & 32'h7FFF_FFF0;
        w.id   = r;
        w.strb = '0;
        for (int i = 0; i < LB; i++) begin
          w.strb[(i + lsb) % LB] = (i < size);
          w.data[i*8 +: 8] = c.q ? src[((i % 4) + b * 4) * 8 +: 8] : src[i*8 +: 8];
        end
        wq.push_back(w);
        a = a + 32'(step);
        remain = remain - size;
      end
      r = r + 6'd1;
    end
  endtask

  // Compare on every clock, then drive and advance the model across the next edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        logic e_cr, e_rv, e_wv, e_ne, acc;
        cmd_t c;
        e_cr = (wq.size() == 0);
        e_rv = (rdq.size() > 0) && (ready_beats == 0);
        e_wv = (ready_beats > 0) && (outst < MAXO);
        e_ne = (wq.size() > 0) || (outst > 0);
        chk("R1", "cmd_ready", 128'(cmd_ready), 128'(e_cr));
        chk("R3", "rd_valid", 128'(rd_valid), 128'(e_rv));
        chk("R13", "wr_valid", 128'(wr_valid), 128'(e_wv));
        chk("R11", "busy_regs", 128'(busy_regs), 128'(act));
        chk("R12", "nempty", 128'(nempty), 128'(e_ne));
        if (e_rv && rd_valid) begin
          chk("R4", "rd_addr", 128'(rd_addr), 128'(rdq[0].a));
          chk("R2", "rd_tag", 128'(rd_tag), 128'(rdq[0].t));
        end
        if (e_wv && wr_valid) begin
          chk("R5 R6 R7", "wr_addr", 128'(wr_addr), 128'(wq[0].addr));
          chk("R5", "wr_id", 128'(wr_id), 128'(wq[0].id));
          chk("R10", "wr_data", wr_data, wq[0].data);
          chk("R8 R9", "wr_strb", 128'(wr_strb), 128'(wq[0].strb));
        end
        cyc++;
        rd_ready   = (cyc % 7) != 3;
        rd_stall   = (cyc % 5) == 1;
        wr_ready   = (cyc % 3) != 2;
        resp_valid = !hold && (outst > 0) && (cyc % 2 == 0);
        acc = e_cr && (cmdq.size() > 0);
        cmd_valid = acc;
        if (acc) begin
          c = cmdq.pop_front();
          cmd_quarter = c.q; cmd_group = c.g; cmd_func = c.fn; cmd_esize = c.es;
          cmd_reg = c.r; cmd_tag = c.t; cmd_addr = c.a; cmd_data = c.d;
        end
        if (resp_valid) outst--;
        if (e_wv && wr_ready) begin
          void'(wq.pop_front());
          ready_beats--;
          outst++;
        end
        if (e_rv && rd_ready && !rd_stall) begin
          rd_t rr;
          rr = rdq.pop_front();
          act[rr.a] = 1'b0;
          ready_beats += rr.beats;
        end
        if (acc) expand(c);
      end
    end
  end

  task automatic push(input logic q, input logic g, input logic [2:0] fn, input logic [2:0] es,
                      input logic [5:0] r, input logic [3:0] t, input logic [31:0] a, input logic [31:0] d);
    cmdq.push_back('{q: q, g: g, fn: fn, es: es, r: r, t: t, a: a, d: d});
  endtask

  task automatic wait_idle();
    while ((cmdq.size() > 0 || wq.size() > 0 || outst > 0) && cyc < LIMIT) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    logic [2:0] es_pick [3] = '{3'd1, 3'd2, 3'd4};
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);           // R1 reset state compared here
    push(0, 0, 3'd0, 3'd1, 6'd5,  4'b0110, 32'h8000_0123, 32'd0);   // R6 R5
    push(0, 0, 3'd1, 3'd2, 6'd6,  4'b1001, 32'h8000_004C, 32'd3);   // R8 R9 wrap
    push(0, 1, 3'd0, 3'd1, 6'd62, 4'b1010, 32'h0000_1000, 32'd0);   // R4 R2 wrap
    push(0, 1, 3'd2, 3'd4, 6'd8,  4'b0011, 32'h8000_2007, 32'h10);  // R7
    push(1, 0, 3'd0, 3'd1, 6'd9,  4'b0100, 32'h0000_3002, 32'd0);   // R10
    push(1, 1, 3'd1, 3'd1, 6'd12, 4'b1111, 32'h8000_300E, 32'd20);  // R10 R8
    push(0, 1, 3'd1, 3'd4, 6'd16, 4'b0001, 32'h0000_4005, 32'd100); // R8 cap
    push(0, 0, 3'd1, 3'd2, 6'd20, 4'b1000, 32'h0000_5009, 32'd0);   // R8 zero
    wait_idle();
    hold = 1;                                                      // R13
    push(1, 1, 3'd2, 3'd2, 6'd30, 4'b0101, 32'h0000_6001, 32'd3);
    repeat (60) @(posedge clk);
    hold = 0;
    wait_idle();
    for (int n = 0; n < 60; n++) begin
      push(1'($urandom), 1'($urandom), 3'($urandom % 4), es_pick[$urandom % 3],
           6'($urandom), 4'($urandom), $urandom, $urandom % 40);
    end
    wait_idle();
    if (cyc >= LIMIT) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1 actual=busy expected=idle");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule